// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Slave Port

This block is the PHY end of a shared, UTOPIA Level 2 style transmit bus, where one ATM-layer master talks to several PHY devices. One device can hold several channels. Each channel has its own address on the shared 5-bit address bus. The master polls an address to ask whether that channel can take another cell. The device answers on the shared cell-available line only when the address belongs to one of its channels. It releases the line at every other time, so another device can answer.

To write a cell, the master places the target address on the bus and then pulls the active-low enable down. The address seen in the cycle just before enable falls picks the channel. Every later cycle with enable low carries one 16-bit word, and start-of-cell marks the first word. A cell is 27 words (54 bytes). The master can keep polling other addresses while a write is in progress, and those polls do not disturb the write. Each channel stores whole cells in its own FIFO. The line side pops them word by word, and a cell becomes visible there only once it is complete.

Top module: `mphy_tx_slave`

## Requirements
- R1: An address that matches a channel is sampled on a rising edge. In the next cycle `clav_oe` is 1, and `clav_o` is 1 exactly when that channel can accept one more whole cell: fewer than FIFO_CELLS cells are stored in it or being written to it.
- R2: An address that matches no channel leaves `clav_oe` at 0 and `clav_o` at 0 in the next cycle. When `clav_oe` is 0, `clav_o` is 0.
- R3: The null address NULL_ADDR (default 0x1F) is never answered, even when a channel is configured with that value.
- R4: The write target is the channel whose address was on `tx_addr` in the cycle before `tx_enb_n` goes from 1 to 0. Words are accepted only in cycles with `tx_enb_n` at 0. The target stays fixed until the next 1-to-0 transition, whatever is polled in the meantime.
- R5: A cell is CELL_WORDS (27) words, and `tx_soc`=1 marks word 0. Words that arrive while the target channel has no cell open are discarded.
- R6: A cell becomes visible (`pop_valid`) only after its last word is written. It is popped in write order with `pop_en`. `pop_soc` is 1 while word 0 is presented. A stored cell stays visible until it is popped.
- R7: A `tx_soc` that arrives before a cell is complete discards the partial cell, starts a new cell with that word as word 0, and sets that channel's `err_flag` bit.
- R8: An `err_flag` bit stays at 1 until reset.
- R9: Each channel holds FIFO_CELLS whole cells. When it is full its poll answer is 0, and a cell whose `tx_soc` arrives while it is full is dropped entirely.
- R10: Channels are independent. A partial cell left in one channel when the master switches the target resumes correctly when that channel is selected again.
- R11: Reset empties every FIFO, clears the selection and all error flags, and leaves `clav_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock |
| rst_n | input | 1 | Active-low reset |
| chan_addr | input | NUM_CH*ADDR_W | Bus address of each channel, channel 0 in the low bits |
| tx_addr | input | ADDR_W | Poll / select address |
| tx_data | input | DATA_W | Cell word |
| tx_enb_n | input | 1 | Active-low write enable |
| tx_soc | input | 1 | Marks word 0 of a cell |
| clav_o | output | 1 | Cell-available value |
| clav_oe | output | 1 | Drive enable for the shared cell-available line |
| pop_en | input | NUM_CH | Pop one word from a channel |
| pop_valid | output | NUM_CH | Channel holds at least one complete cell |
| pop_soc | output | NUM_CH | Presented word is word 0 of a cell |
| pop_data | output | NUM_CH*DATA_W | Presented word of each channel |
| err_flag | output | NUM_CH | Sticky early start-of-cell flag per channel |

## Verification
The bench builds the block with three channels and FIFO_CELLS set to 2, so a channel fills after two cells. This makes the full answer and the dropped third cell quick to reach. One channel is configured with the null address, which shows that a configured value of 0x1F is still never answered. The other two channels are written in interleaved order. Polls to the null address, to an unused address and to the other channel run during every transfer.

// File: rtl/mphy_tx_pkg.sv
package mphy_tx_pkg;
   localparam int unsigned ADDR_W_DEF     = 5;
   localparam int unsigned DATA_W_DEF     = 16;
   localparam int unsigned CELL_WORDS_DEF = 27;
   localparam int unsigned FIFO_CELLS_DEF = 4;
   localparam int unsigned NUM_CH_DEF     = 4;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mphy_addr_match.sv
module mphy_addr_match #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 5,
   parameter logic [ADDR_W-1:0] NULL_ADDR = '1,
   parameter int unsigned IW = 2
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NUM_CH*ADDR_W-1:0] chan_addr,
   output logic                     hit,
   output logic [IW-1:0]            idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      if (addr != NULL_ADDR) begin
         for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (chan_addr[i*ADDR_W +: ADDR_W] == addr) begin
               hit = 1'b1;
               idx = IW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/mphy_wr_select.sv
module mphy_wr_select #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 5,
   parameter logic [ADDR_W-1:0] NULL_ADDR = '1,
   parameter int unsigned IW = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        tx_addr,
   input  logic                     tx_enb_n,
   input  logic [NUM_CH*ADDR_W-1:0] chan_addr,
   output logic                     wr_valid,
   output logic [IW-1:0]            wr_ch
);
   logic [ADDR_W-1:0] prev_addr_q;
   logic              prev_enb_n_q;
   logic              sel_hit_q;
   logic [IW-1:0]     sel_idx_q;
   logic              m_hit;
   logic [IW-1:0]     m_idx;
   logic              enb_fall;
   logic              eff_hit;

   mphy_addr_match #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .NULL_ADDR(NULL_ADDR), .IW(IW)
   ) u_prev_match (
      .addr(prev_addr_q), .chan_addr(chan_addr), .hit(m_hit), .idx(m_idx)
   );

   assign enb_fall = !tx_enb_n && prev_enb_n_q;
   assign eff_hit  = enb_fall ? m_hit : sel_hit_q;
   assign wr_ch    = enb_fall ? m_idx : sel_idx_q;
   assign wr_valid = !tx_enb_n && eff_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_addr_q  <= NULL_ADDR;
         prev_enb_n_q <= 1'b1;
         sel_hit_q    <= 1'b0;
         sel_idx_q    <= '0;
      end else begin
         prev_addr_q  <= tx_addr;
         prev_enb_n_q <= tx_enb_n;
         if (enb_fall) begin
            sel_hit_q <= m_hit;
            sel_idx_q <= m_idx;
         end
      end
   end
endmodule

// File: rtl/mphy_cell_fifo.sv
module mphy_cell_fifo #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CELL_WORDS = 27,
   parameter int unsigned FIFO_CELLS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_soc,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop_en,
   output logic              pop_valid,
   output logic              pop_soc,
   output logic [DATA_W-1:0] pop_data,
   output logic              room,
   output logic              err
);
   localparam int unsigned WW    = $clog2(CELL_WORDS);
   localparam int unsigned NW    = $clog2(FIFO_CELLS + 1);
   localparam int unsigned CPW   = (FIFO_CELLS > 1) ? $clog2(FIFO_CELLS) : 1;
   localparam int unsigned DEPTH = FIFO_CELLS * CELL_WORDS;
   localparam int unsigned AW    = $clog2(DEPTH);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [WW-1:0]     wr_word_q, rd_word_q, st_word;
   logic [CPW-1:0]    wr_cell_q, rd_cell_q, wr_cell_nx, rd_cell_nx;
   logic [NW-1:0]     cnt_q;
   logic              wr_act_q, err_q;
   logic              soc_ok, store, wr_last, pop_fire, rd_last;
   logic [AW-1:0]     wr_idx, rd_idx;

   generate
      if (FIFO_CELLS == 1) begin : g_one_cell
         assign wr_cell_nx = '0;
         assign rd_cell_nx = '0;
      end else begin : g_ring
         assign wr_cell_nx = (wr_cell_q == CPW'(FIFO_CELLS - 1)) ? '0 : wr_cell_q + 1'b1;
         assign rd_cell_nx = (rd_cell_q == CPW'(FIFO_CELLS - 1)) ? '0 : rd_cell_q + 1'b1;
      end
   endgenerate

   assign soc_ok   = wr_soc && (wr_act_q || (cnt_q < NW'(FIFO_CELLS)));
   assign store    = wr_en && (wr_soc ? soc_ok : wr_act_q);
   assign st_word  = wr_soc ? '0 : wr_word_q;
   assign wr_last  = store && (st_word == WW'(CELL_WORDS - 1));
   assign pop_fire = pop_en && (cnt_q != '0);
   assign rd_last  = (rd_word_q == WW'(CELL_WORDS - 1));
   assign wr_idx   = AW'(wr_cell_q) * AW'(CELL_WORDS) + AW'(st_word);
   assign rd_idx   = AW'(rd_cell_q) * AW'(CELL_WORDS) + AW'(rd_word_q);

   assign pop_valid = (cnt_q != '0);
   assign pop_soc   = pop_valid && (rd_word_q == '0);
   assign pop_data  = mem_q[rd_idx];
   assign room      = ({1'b0, cnt_q} + {{NW{1'b0}}, wr_act_q}) < (NW + 1)'(FIFO_CELLS);
   assign err       = err_q;

   always_ff @(posedge clk) begin
      if (store) mem_q[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_word_q <= '0;
         rd_word_q <= '0;
         wr_cell_q <= '0;
         rd_cell_q <= '0;
         cnt_q     <= '0;
         wr_act_q  <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         if (store) begin
            wr_word_q <= wr_last ? '0 : st_word + 1'b1;
            wr_act_q  <= !wr_last;
            if (wr_last) wr_cell_q <= wr_cell_nx;
         end
         if (wr_en && wr_soc && wr_act_q) err_q <= 1'b1;
         if (pop_fire) begin
            rd_word_q <= rd_last ? '0 : rd_word_q + 1'b1;
            if (rd_last) rd_cell_q <= rd_cell_nx;
         end
         case ({wr_last, pop_fire && rd_last})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/mphy_tx_slave.sv
module mphy_tx_slave #(
   parameter int unsigned NUM_CH     = mphy_tx_pkg::NUM_CH_DEF,
   parameter int unsigned ADDR_W     = mphy_tx_pkg::ADDR_W_DEF,
   parameter int unsigned DATA_W     = mphy_tx_pkg::DATA_W_DEF,
   parameter int unsigned CELL_WORDS = mphy_tx_pkg::CELL_WORDS_DEF,
   parameter int unsigned FIFO_CELLS = mphy_tx_pkg::FIFO_CELLS_DEF,
   parameter logic [ADDR_W-1:0] NULL_ADDR = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*ADDR_W-1:0] chan_addr,
   input  logic [ADDR_W-1:0]        tx_addr,
   input  logic [DATA_W-1:0]        tx_data,
   input  logic                     tx_enb_n,
   input  logic                     tx_soc,
   output logic                     clav_o,
   output logic                     clav_oe,
   input  logic [NUM_CH-1:0]        pop_en,
   output logic [NUM_CH-1:0]        pop_valid,
   output logic [NUM_CH-1:0]        pop_soc,
   output logic [NUM_CH*DATA_W-1:0] pop_data,
   output logic [NUM_CH-1:0]        err_flag
);
   localparam int unsigned IW = mphy_tx_pkg::idx_w(NUM_CH);

   generate
      if (NUM_CH < 1 || NUM_CH >= (1 << ADDR_W)) begin : g_bad_num_ch
         $error("NUM_CH must be 1 .. 2**ADDR_W-1");
      end
      if (CELL_WORDS < 2) begin : g_bad_cell
         $error("CELL_WORDS must be at least 2");
      end
      if (FIFO_CELLS < 1) begin : g_bad_depth
         $error("FIFO_CELLS must be at least 1");
      end
   endgenerate

   logic              poll_hit;
   logic [IW-1:0]     poll_idx;
   logic              wr_valid;
   logic [IW-1:0]     wr_ch;
   logic [NUM_CH-1:0] room;
   logic              clav_q, clav_oe_q;

   mphy_addr_match #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .NULL_ADDR(NULL_ADDR), .IW(IW)
   ) u_poll_match (
      .addr(tx_addr), .chan_addr(chan_addr), .hit(poll_hit), .idx(poll_idx)
   );

   mphy_wr_select #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .NULL_ADDR(NULL_ADDR), .IW(IW)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n),
      .chan_addr(chan_addr), .wr_valid(wr_valid), .wr_ch(wr_ch)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         mphy_cell_fifo #(
            .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .FIFO_CELLS(FIFO_CELLS)
         ) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_valid && (wr_ch == IW'(c))),
            .wr_soc(tx_soc), .wr_data(tx_data),
            .pop_en(pop_en[c]), .pop_valid(pop_valid[c]), .pop_soc(pop_soc[c]),
            .pop_data(pop_data[c*DATA_W +: DATA_W]),
            .room(room[c]), .err(err_flag[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clav_q    <= 1'b0;
         clav_oe_q <= 1'b0;
      end else begin
         clav_oe_q <= poll_hit;
         clav_q    <= poll_hit && room[poll_idx];
      end
   end

   assign clav_o  = clav_q;
   assign clav_oe = clav_oe_q;
endmodule

// File: rtl/mphy_tx_slave_chk.sv
module mphy_tx_slave_chk #(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CELL_WORDS = 27,
   parameter int unsigned FIFO_CELLS = 4,
   parameter logic [ADDR_W-1:0] NULL_ADDR = '1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CH*ADDR_W-1:0] chan_addr,
   input logic [ADDR_W-1:0]        tx_addr,
   input logic [DATA_W-1:0]        tx_data,
   input logic                     tx_enb_n,
   input logic                     tx_soc,
   input logic                     clav_o,
   input logic                     clav_oe,
   input logic [NUM_CH-1:0]        pop_en,
   input logic [NUM_CH-1:0]        pop_valid,
   input logic [NUM_CH-1:0]        pop_soc,
   input logic [NUM_CH*DATA_W-1:0] pop_data,
   input logic [NUM_CH-1:0]        err_flag
);
   logic any_match;
   always_comb begin
      any_match = 1'b0;
      for (int i = 0; i < NUM_CH; i++)
         if (chan_addr[i*ADDR_W +: ADDR_W] == tx_addr) any_match = 1'b1;
   end

   AST_NULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_addr == NULL_ADDR) |=> !clav_oe);  // R3
   AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !any_match |=> !clav_oe);  // R2
   AST_CLAV_LOW_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !clav_oe |-> !clav_o);  // R2

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
         AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            err_flag[c] |=> err_flag[c]);  // R8
         AST_CELL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_valid[c] && !pop_en[c]) |=> pop_valid[c]);  // R6
         AST_SOC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            pop_soc[c] |-> pop_valid[c]);  // R6
      end
   endgenerate
endmodule

bind mphy_tx_slave mphy_tx_slave_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .CELL_WORDS(CELL_WORDS), .FIFO_CELLS(FIFO_CELLS), .NULL_ADDR(NULL_ADDR)
) u_chk (.*);

// File: tb/mphy_tx_slave_tb.sv
`timescale 1ns/1ps
module mphy_tx_slave_tb;
   localparam int NCH = 3;
   localparam int AW  = 5;
   localparam int DW  = 16;
   localparam int CW  = 27;
   localparam int FC  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*AW-1:0] chan_addr = {5'h1F, 5'h02, 5'h00};
   logic [AW-1:0]     tx_addr = 5'h1F;
   logic [DW-1:0]     tx_data = '0;
   logic              tx_enb_n = 1'b1;
   logic              tx_soc = 1'b0;
   logic              clav_o, clav_oe;
   logic [NCH-1:0]    pop_en = '0;
   logic [NCH-1:0]    pop_valid, pop_soc, err_flag;
   logic [NCH*DW-1:0] pop_data;
   logic [NCH-1:0]    drain = '0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 0;
   logic [16:0] exp_q [NCH][$];

   always #5 clk = ~clk;

   mphy_tx_slave #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .CELL_WORDS(CW),
                   .FIFO_CELLS(FC)) u_dut (
      .clk(clk), .rst_n(rst_n), .chan_addr(chan_addr), .tx_addr(tx_addr),
      .tx_data(tx_data), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
      .clav_o(clav_o), .clav_oe(clav_oe), .pop_en(pop_en),
      .pop_valid(pop_valid), .pop_soc(pop_soc), .pop_data(pop_data),
      .err_flag(err_flag));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops enabled channels and compares against the scoreboard
   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (rst_n && drain[c] && pop_valid[c]) begin
            if (exp_q[c].size() == 0) begin
               check(0, "R6", "unexpected word", int'(pop_data[c*DW +: DW]), 0);
            end else begin
               logic [16:0] e;
               e = exp_q[c].pop_front();
               check({pop_soc[c], pop_data[c*DW +: DW]} == e, "R6",
                     $sformatf("ch%0d word", c),
                     int'({pop_soc[c], pop_data[c*DW +: DW]}), int'(e));
            end
            pop_en[c] = 1'b1;
         end else begin
            pop_en[c] = 1'b0;
         end
      end
   end

   task automatic idle(input int n, input logic [AW-1:0] a);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_enb_n = 1'b1; tx_soc = 1'b0; tx_addr = a;
      end
   endtask

   task automatic select(input logic [AW-1:0] a);
      @(negedge clk);
      tx_enb_n = 1'b1; tx_soc = 1'b0; tx_addr = a;
   endtask

   task automatic word(input logic [DW-1:0] d, input bit soc, input logic [AW-1:0] poll);
      @(negedge clk);
      tx_enb_n = 1'b0; tx_data = d; tx_soc = soc; tx_addr = poll;
   endtask

   task automatic push_cell(input int ch, input logic [DW-1:0] base);
      for (int k = 0; k < CW; k++) exp_q[ch].push_back({(k == 0), base + DW'(k)});
   endtask

   // words k0..k1 of a cell; polls null, unused, then the other channel
   task automatic words(input logic [DW-1:0] base, input int k0, input int k1,
                        input logic [AW-1:0] other);
      logic [AW-1:0] last_poll;
      last_poll = 5'h00;
      for (int k = k0; k <= k1; k++) begin
         logic [AW-1:0] p;
         p = (k % 3 == 0) ? 5'h1F : (k % 3 == 1) ? 5'h07 : other;
         word(base + DW'(k), (k == 0), p);
         if (k > k0)
            check(clav_oe == (last_poll == other), "R4", "poll during transfer oe",
                  int'(clav_oe), int'(last_poll == other));
         last_poll = p;
      end
   endtask

   task automatic poll(input logic [AW-1:0] a, input bit eoe, input bit eclav,
                       input string req);
      @(negedge clk);
      tx_enb_n = 1'b1; tx_soc = 1'b0; tx_addr = a;
      @(negedge clk);
      check(clav_oe == eoe, req, $sformatf("oe for %0h", a), int'(clav_oe), int'(eoe));
      check(clav_o == eclav, req, $sformatf("clav for %0h", a), int'(clav_o), int'(eclav));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(clav_oe == 0, "R11", "reset oe", int'(clav_oe), 0);
      check(pop_valid == 0, "R11", "reset pop_valid", int'(pop_valid), 0);
      check(err_flag == 0, "R11", "reset err", int'(err_flag), 0);
      rst_n = 1'b1;

      poll(5'h00, 1, 1, "R1");
      poll(5'h07, 0, 0, "R2");
      poll(5'h1F, 0, 0, "R3");

      // R6: visibility only after the last word
      select(5'h00);
      for (int k = 0; k < CW; k++) begin
         word(16'hA000 + DW'(k), (k == 0), 5'h07);
         if (k == CW - 1)
            check(pop_valid[0] == 0, "R6", "partial cell hidden", int'(pop_valid[0]), 0);
      end
      idle(1, 5'h07);
      check(pop_valid[0] == 1, "R6", "complete cell visible", int'(pop_valid[0]), 1);
      check(pop_soc[0] == 1, "R6", "soc flag on word 0", int'(pop_soc[0]), 1);
      check(pop_data[DW-1:0] == 16'hA000, "R6", "word 0 data", int'(pop_data[DW-1:0]), 'hA000);
      push_cell(0, 16'hA000);
      drain[0] = 1'b1;
      idle(35, 5'h07);

      // R9: fill channel 1 (FIFO_CELLS=2), third cell dropped
      select(5'h02); push_cell(1, 16'h1000); words(16'h1000, 0, CW - 1, 5'h00);
      poll(5'h02, 1, 1, "R9");
      select(5'h02); push_cell(1, 16'h2000); words(16'h2000, 0, CW - 1, 5'h00);
      poll(5'h02, 1, 0, "R9");
      poll(5'h00, 1, 1, "R10");
      select(5'h02); words(16'h3000, 0, CW - 1, 5'h00);
      poll(5'h02, 1, 0, "R9");
      drain[1] = 1'b1;
      idle(80, 5'h07);
      check(pop_valid[1] == 0, "R9", "dropped cell absent", int'(pop_valid[1]), 0);
      check(exp_q[1].size() == 0, "R9", "ch1 cells left", exp_q[1].size(), 0);
      poll(5'h02, 1, 1, "R9");

      // R5: stray words without an open cell
      select(5'h00);
      word(16'hBEEF, 0, 5'h07); word(16'hBEEF, 0, 5'h07); word(16'hBEEF, 0, 5'h07);
      idle(3, 5'h07);
      check(pop_valid[0] == 0, "R5", "stray words discarded", int'(pop_valid[0]), 0);

      // R7: early start-of-cell
      check(err_flag[0] == 0, "R7", "err before", int'(err_flag[0]), 0);
      select(5'h00);
      words(16'hC000, 0, 9, 5'h02);
      push_cell(0, 16'hD000);
      words(16'hD000, 0, CW - 1, 5'h02);
      idle(40, 5'h07);
      check(err_flag[0] == 1, "R7", "err set on ch0", int'(err_flag[0]), 1);
      check(err_flag[1] == 0, "R7", "err clear on ch1", int'(err_flag[1]), 0);
      check(exp_q[0].size() == 0, "R7", "ch0 cells left", exp_q[0].size(), 0);

      // R10: interleaved partial cell
      select(5'h00); push_cell(0, 16'hE000); words(16'hE000, 0, 9, 5'h02);
      select(5'h02); push_cell(1, 16'hF000); words(16'hF000, 0, CW - 1, 5'h00);
      select(5'h00); words(16'hE000, 10, CW - 1, 5'h02);
      idle(80, 5'h07);
      check(exp_q[0].size() == 0, "R10", "ch0 cells left", exp_q[0].size(), 0);
      check(exp_q[1].size() == 0, "R10", "ch1 cells left", exp_q[1].size(), 0);
      check(pop_valid == 0, "R10", "all drained", int'(pop_valid), 0);
      check(err_flag[0] == 1, "R8", "err still set", int'(err_flag[0]), 1);

      // R11: reset clears stored cells and flags
      drain = '0;
      select(5'h00); words(16'h5000, 0, CW - 1, 5'h02);
      idle(1, 5'h00);
      check(pop_valid[0] == 1, "R11", "cell stored before reset", int'(pop_valid[0]), 1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(pop_valid == 0, "R11", "fifo emptied", int'(pop_valid), 0);
      check(err_flag == 0, "R11", "err cleared", int'(err_flag), 0);
      check(clav_oe == 0, "R11", "oe released", int'(clav_oe), 0);
      rst_n = 1'b1;
      poll(5'h00, 1, 1, "R11");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule